// File: doc/BRIEF.md
# Power-On Self-Test Code Capture FIFO

This block collects the 8-bit progress codes that host firmware emits while it runs its power-on self-test. The host writes each code to one of two capture offsets inside a small decoded port window. The block queues the codes in a 32-entry first-in first-out store so that software or a service agent can collect them later. A separate read offset removes the oldest code, and a status offset reports how many codes are held along with the empty, full and overflow flags.

When a capture write arrives and no slot is free, the code is discarded and a sticky overflow flag is raised. That flag drives the interrupt output. Only writes to the two capture offsets can raise it. Every other bus access leaves it alone, and so do reads of an empty store, which return zero without moving anything. The bus itself is reduced to single-cycle read and write strobes with a 3-bit offset. Read results appear on a registered data output one cycle after the strobe.

Top module: `postcode_fifo`

## Requirements
- R1: After reset the store is empty, the status word reads 20h (empty flag only), irqOut is 0 and rdData is 00h.
- R2: A wrStb at offset 0 or offset 4 stores wrData. A rdStb at offset 5 returns the oldest stored code on rdData in the cycle after the strobe and removes it, so codes come back in the order they were written, whichever capture offset each one used.
- R3: The store holds at most 32 codes. A capture write while 32 codes are held is dropped, and the stored codes and the count stay unchanged.
- R4: A capture write while the store is full sets the overflow flag. irqOut goes to 1 in the cycle after that write and stays at 1 until reset, even after codes are drained.
- R5: A wrStb at any offset other than 0 or 4 stores nothing and never sets the overflow flag or irqOut, even when the store is full.
- R6: A rdStb at offset 5 while the store is empty returns 00h and leaves the count and the read position unchanged.
- R7: A rdStb at offset 6 returns the status word: bit 7 is the overflow flag, bit 6 is full, bit 5 is empty, and bits 4:0 are the number of codes held, modulo 32 (so a full store reads count 0 with bit 6 set). The status read does not change any state.
- R8: A rdStb at any offset other than 5 or 6 returns 00h and removes nothing. rdData keeps its last value in cycles without a rdStb.
- R9: A reset applied mid-run clears the count, both positions and the overflow flag, so the first code written afterwards is the first one read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | Single-cycle write strobe |
| rdStb | input | 1 | Single-cycle read strobe |
| portOfs | input | 3 | Offset within the decoded port window |
| wrData | input | 8 | Code written on a write strobe |
| rdData | output | 8 | Registered read result, valid the cycle after rdStb |
| irqOut | output | 1 | Overflow interrupt, level, sticky until reset |

## Verification
A directed sequence fills the store through both capture offsets in turn. This shows that the two write offsets feed one common queue in arrival order. It then attempts writes at each non-capture offset while the store is full, which separates a correct offset decode from one that accepts any write or raises the interrupt on any write. A further capture write while full checks both the drop and the interrupt. The store is then drained past empty, which shows the zero result and the unmoved pointers. A reset taken mid-run is followed by a write and a read, to confirm that the positions were cleared. Seeded random streams of mixed reads and writes over all eight offsets, checked against a queue model, cover the pointer wrap at many fill levels and the status encoding as occupancy rises and falls.

// File: rtl/postcode_pkg.sv
package postcode_pkg;

  // Strobes the control half hands to the datapath half each cycle.
  typedef struct packed {
    logic push;        // store wrData at the write position
    logic loadEntry;   // capture the oldest entry into rdData
    logic loadStatus;  // capture the status word into rdData
    logic loadZero;    // capture zero into rdData
  } postStrobe_t;

endpackage

// File: rtl/postcode_ctrl.sv
module postcode_ctrl
  import postcode_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned OFS_W = 3,
  parameter logic [OFS_W-1:0] WR_OFS_A = OFS_W'(0),
  parameter logic [OFS_W-1:0] WR_OFS_B = OFS_W'(4),
  parameter logic [OFS_W-1:0] RD_DATA_OFS = OFS_W'(5),
  parameter logic [OFS_W-1:0] RD_STAT_OFS = OFS_W'(6),
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [OFS_W-1:0] portOfs,
  output postStrobe_t      strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] fillCount,
  output logic             isFull,
  output logic             isEmpty,
  output logic             ovfFlag
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic captureHit;
  logic dataReadHit;
  logic statReadHit;
  logic doPush;
  logic doPop;
  logic overflowHit;

  // Port decode
  assign captureHit  = wrStb && ((portOfs == WR_OFS_A) || (portOfs == WR_OFS_B));
  assign dataReadHit = rdStb && (portOfs == RD_DATA_OFS);
  assign statReadHit = rdStb && (portOfs == RD_STAT_OFS);

  assign isFull  = (fillCount == FULL_CNT);
  assign isEmpty = (fillCount == '0);

  assign doPush      = captureHit && !isFull;
  assign overflowHit = captureHit && isFull;
  assign doPop       = dataReadHit && !isEmpty;

  always_comb begin
    strb            = '0;
    strb.push       = doPush;
    strb.loadEntry  = doPop;
    strb.loadStatus = statReadHit;
    strb.loadZero   = rdStb && !doPop && !statReadHit;
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (doPush) begin
      wrPtr <= nextPtr(wrPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (doPop) begin
      rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      unique case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (overflowHit) begin
      ovfFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/postcode_dpath.sv
module postcode_dpath
  import postcode_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  postStrobe_t       strb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [CNT_W-1:0]  fillCount,
  input  logic              isFull,
  input  logic              isEmpty,
  input  logic              ovfFlag,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] codeMem [DEPTH];
  logic [DATA_W-1:0] statusWord;

  // Entry storage, no reset needed: occupancy lives in the control half.
  always_ff @(posedge clk) begin
    if (strb.push) begin
      codeMem[wrPtr] <= wrData;
    end
  end

  // Status layout: flags in the three top bits, count in the low bits.
  always_comb begin
    statusWord             = '0;
    statusWord[DATA_W-1]   = ovfFlag;
    statusWord[DATA_W-2]   = isFull;
    statusWord[DATA_W-3]   = isEmpty;
    statusWord[PTR_W-1:0]  = fillCount[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.loadEntry) begin
      rdData <= codeMem[rdPtr];
    end else if (strb.loadStatus) begin
      rdData <= statusWord;
    end else if (strb.loadZero) begin
      rdData <= '0;
    end
  end

endmodule

// File: rtl/postcode_fifo.sv
module postcode_fifo
  import postcode_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned OFS_W = 3,
  parameter logic [OFS_W-1:0] WR_OFS_A = OFS_W'(0),
  parameter logic [OFS_W-1:0] WR_OFS_B = OFS_W'(4),
  parameter logic [OFS_W-1:0] RD_DATA_OFS = OFS_W'(5),
  parameter logic [OFS_W-1:0] RD_STAT_OFS = OFS_W'(6)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [OFS_W-1:0]  portOfs,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  postStrobe_t      strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fillCount;
  logic             isFull;
  logic             isEmpty;
  logic             ovfFlag;

  postcode_ctrl #(
    .DEPTH(DEPTH), .OFS_W(OFS_W),
    .WR_OFS_A(WR_OFS_A), .WR_OFS_B(WR_OFS_B),
    .RD_DATA_OFS(RD_DATA_OFS), .RD_STAT_OFS(RD_STAT_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .portOfs(portOfs),
    .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr), .fillCount(fillCount),
    .isFull(isFull), .isEmpty(isEmpty), .ovfFlag(ovfFlag)
  );

  postcode_dpath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fillCount(fillCount), .isFull(isFull), .isEmpty(isEmpty),
    .ovfFlag(ovfFlag), .wrData(wrData), .rdData(rdData)
  );

  assign irqOut = ovfFlag;

endmodule

// File: rtl/postcode_fifo_chk.sv
module postcode_fifo_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned OFS_W = 3,
  parameter logic [OFS_W-1:0] WR_OFS_A = OFS_W'(0),
  parameter logic [OFS_W-1:0] WR_OFS_B = OFS_W'(4),
  parameter logic [OFS_W-1:0] RD_DATA_OFS = OFS_W'(5),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic              rdStb,
  input logic [OFS_W-1:0]  portOfs,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic [CNT_W-1:0]  fillCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic captureWr;
  assign captureWr = wrStb && ((portOfs == WR_OFS_A) || (portOfs == WR_OFS_B));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (captureWr && fillCount == FULL_CNT) |=> (fillCount == FULL_CNT));

  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> irqOut);

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(captureWr && fillCount == FULL_CNT));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && portOfs == RD_DATA_OFS && fillCount == '0)
      |=> (rdData == '0 && fillCount == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount != $past(fillCount)) |->
      ((fillCount == $past(fillCount) + 1'b1) || (fillCount + 1'b1 == $past(fillCount))));

endmodule

bind postcode_fifo postcode_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .OFS_W(OFS_W),
  .WR_OFS_A(WR_OFS_A), .WR_OFS_B(WR_OFS_B), .RD_DATA_OFS(RD_DATA_OFS)
) chk_i (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .portOfs(portOfs),
  .rdData(rdData), .irqOut(irqOut), .fillCount(fillCount)
);

// File: tb/postcode_fifo_tb.sv
module postcode_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [2:0] portOfs = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model of the queue
  logic [7:0] modelQ[$];
  bit         modelOvf;

  always #10 clk = ~clk;  // 50 MHz

  postcode_fifo dut_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb),
    .portOfs(portOfs), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  function automatic logic [7:0] expStatus();
    int n = modelQ.size();
    return {modelOvf, n == 32, n == 0, 5'(n % 32)};
  endfunction

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; wrStb = 1'b0; rdStb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelQ.delete();
    modelOvf = 1'b0;
  endtask

  task automatic busWrite(input logic [2:0] ofs, input logic [7:0] val);
    @(negedge clk);
    portOfs = ofs; wrData = val; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    if (ofs == 3'd0 || ofs == 3'd4) begin
      if (modelQ.size() < 32) modelQ.push_back(val);
      else modelOvf = 1'b1;
    end
  endtask

  task automatic busRead(input logic [2:0] ofs, output logic [7:0] val,
                         output logic [7:0] expVal);
    @(negedge clk);
    portOfs = ofs; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    val = rdData;
    if (ofs == 3'd5) expVal = (modelQ.size() > 0) ? modelQ.pop_front() : 8'h00;
    else if (ofs == 3'd6) expVal = expStatus();
    else expVal = 8'h00;
  endtask

  task automatic readCheck(input string tag, input logic [2:0] ofs);
    logic [7:0] got, exp;
    busRead(ofs, got, exp);
    check(tag, got, exp);
  endtask

  initial begin
    int seedDummy;
    logic [7:0] got, exp;
    seedDummy = $urandom(32'd20240611);
    modelOvf = 1'b0;

    applyReset();
    // R1: reset state
    check("R1 rdData after reset", rdData, 8'h00);
    check("R1 irqOut after reset", irqOut, 0);
    busRead(3'd6, got, exp);
    check("R1 status after reset", got, 8'h20);

    // R2: fill through both capture offsets alternately
    for (int i = 0; i < 32; i++) busWrite((i % 2 == 0) ? 3'd0 : 3'd4, 8'(8'hA0 + i));
    busRead(3'd6, got, exp);
    check("R7 status when full", got, 8'h40);

    // R5: writes at non-capture offsets while full
    for (int o = 1; o < 8; o++) begin
      if (o != 4) begin
        busWrite(3'(o), 8'h55);
        check("R5 irqOut after non-capture write", irqOut, 0);
      end
    end
    readCheck("R5 status after non-capture writes", 3'd6);

    // R3 / R4: write while full
    busWrite(3'd4, 8'hEE);
    check("R4 irqOut after overflow", irqOut, 1);
    busRead(3'd6, got, exp);
    check("R4 status after overflow", got, 8'hC0);

    // R8: other read offsets return zero, do not pop
    readCheck("R8 read at offset 0", 3'd0);
    readCheck("R8 read at offset 7", 3'd7);
    @(negedge clk);
    check("R8 rdData held without strobe", rdData, 8'h00);

    // R2 / R3: drain in order, dropped code never appears
    for (int i = 0; i < 32; i++) readCheck("R2 drain order", 3'd5);
    check("R4 irqOut stays after drain", irqOut, 1);

    // R6: read empty twice
    readCheck("R6 empty read", 3'd5);
    readCheck("R6 empty read again", 3'd5);
    readCheck("R6 status after empty reads", 3'd6);

    // R9: reset mid-run
    busWrite(3'd0, 8'h11);
    busWrite(3'd0, 8'h22);
    applyReset();
    check("R9 irqOut cleared by reset", irqOut, 0);
    busWrite(3'd4, 8'h77);
    readCheck("R9 first code after reset", 3'd5);
    readCheck("R9 status after reset", 3'd6);

    // Random mixed traffic
    for (int pass = 0; pass < 3; pass++) begin
      applyReset();
      for (int n = 0; n < 3000; n++) begin
        int r = int'($urandom % 100);
        int wBias = (pass == 1) ? 70 : 52;
        if (r < wBias) begin
          logic [2:0] ofs = ($urandom % 8 < 6) ? (($urandom % 2) ? 3'd0 : 3'd4) : 3'($urandom % 8);
          busWrite(ofs, 8'($urandom));
          check("R4 R5 irqOut random", irqOut, int'(modelOvf));
        end else begin
          logic [2:0] ofs = ($urandom % 8 < 6) ? 3'd5 : 3'($urandom % 8);
          readCheck((ofs == 3'd5) ? "R2 R6 random pop" :
                    (ofs == 3'd6) ? "R7 random status" : "R8 random other read", ofs);
        end
      end
      readCheck("R7 status at end of random pass", 3'd6);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule